// File: doc/BRIEF.md
# Direct-Mapped Instruction and Data Address Translator

This block translates 32-bit virtual addresses into physical addresses for a processor pipeline. It has two separate direct-mapped tables: one serves instruction fetches and the other serves loads and stores. Each table entry holds a tag word and a translation word. Software fills the entries through a single-cycle write port. The block never refills an entry by itself.

A lookup presents a virtual address, the access kind and the privilege level on a request strobe. One cycle later the block answers with a response strobe. The response carries either a physical address with its granted rights, or a failure class with the exception code the core should take. On every failure it also latches the offending virtual address. When translation is switched off, addresses pass through unchanged with every right granted.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is high and right after it, `rsp_valid` is 0 and `fault_addr` is 0.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. A lookup sees every entry write made in an earlier cycle. A write in the same cycle as the request is not yet seen.
- R3: The entry index is `vaddr[18:13]`. A hit needs tag-word bits [31:13] to equal `vaddr[31:13]` in full. Any difference gives status 1 (no match).
- R4: Bit 0 of the tag word is the valid flag. When the tag matches but the flag is 0, the status is 2 (invalid).
- R5: A fetch (kind 0) uses only the instruction table. Translation-word bit 7 grants execute in supervisor mode and bit 6 grants it in user mode. A fetch without execute right gives status 3 (rights fault). `rsp_perm` is {read, write, execute}, so a fetch hit reports 3'b001.
- R6: Loads (kind 1) and stores (kind 2) use only the data table. User mode takes read from bit 6 and write from bit 7. Supervisor mode takes read from bit 8 and write from bit 9. A load needs read and a store needs write, or the status is 3. A data hit reports {read, write, 0}.
- R7: On a hit (status 0), `rsp_paddr` is translation-word bits [31:13] joined with `vaddr[12:0]`.
- R8: `rsp_exc` is 0 on success. No match or invalid gives 1 for a fetch and 2 for a load or store. A rights fault gives 3 for a fetch and 4 for a load or store.
- R9: Every response with a nonzero status loads its virtual address into `fault_addr`, visible in the same cycle as `rsp_valid`. Any other cycle leaves `fault_addr` unchanged.
- R10: With `xlat_en` low, a lookup returns `rsp_paddr` equal to the virtual address, `rsp_perm` 3'b111, status 0 and exception 0, whatever the tables hold.
- R11: A response with a nonzero status drives `rsp_paddr` and `rsp_perm` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | 1 = translate, 0 = pass addresses through |
| cfg_we | input | 1 | Entry write strobe |
| cfg_itlb | input | 1 | 1 = instruction table, 0 = data table |
| cfg_xr | input | 1 | 1 = translation word, 0 = tag word |
| cfg_idx | input | 6 | Entry index to write |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Lookup request strobe |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store (3 reserved) |
| req_super | input | 1 | 1 = supervisor mode |
| req_vaddr | input | 32 | Virtual address |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 3 | Granted rights {read, write, execute} |
| rsp_status | output | 2 | 0 hit, 1 no match, 2 invalid, 3 rights fault |
| rsp_exc | output | 3 | Exception code, 0 none |
| fault_addr | output | 32 | Last faulting virtual address |

## Verification
A corrupted table entry or a wrong table choice shows up at the ports on the very next response. It appears as a wrong status, a wrong frame number or a wrong rights vector. A swapped rights bit shows only under one combination of privilege level and access kind. For that reason the random sweep varies both while hitting entries that are present. A faulty capture register leaves `fault_addr` stale, or changes it on a hit. A reference queue is compared on every response, so this is seen on the first failing or succeeding lookup that follows.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  // access kinds on req_kind
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_LOAD  = 2'd1;
  localparam logic [1:0] KIND_STORE = 2'd2;

  // rights nibble: lowest bit position inside the translation word, and width
  localparam int RIGHTS_LO = 6;
  localparam int RIGHTS_W  = 4;

  // table index for each side
  localparam int SIDE_INSN = 0;
  localparam int SIDE_DATA = 1;
  localparam int SIDES     = 2;

  typedef enum logic [1:0] {
    XS_HIT     = 2'd0,
    XS_NOMATCH = 2'd1,
    XS_INVALID = 2'd2,
    XS_RIGHTS  = 2'd3
  } xl_status_e;

  typedef enum logic [2:0] {
    XE_NONE      = 3'd0,
    XE_INSN_MISS = 3'd1,
    XE_DATA_MISS = 3'd2,
    XE_INSN_PAGE = 3'd3,
    XE_DATA_PAGE = 3'd4
  } xl_exc_e;

  function automatic xl_exc_e exc_of(xl_status_e st, logic fetch);
    case (st)
      XS_NOMATCH, XS_INVALID: return fetch ? XE_INSN_MISS : XE_DATA_MISS;
      XS_RIGHTS:              return fetch ? XE_INSN_PAGE : XE_DATA_PAGE;
      default:                return XE_NONE;
    endcase
  endfunction

endpackage

// File: rtl/tlb_table.sv
// One direct-mapped table: a tag array and a translation array sharing an index.
module tlb_table #(
  parameter int IDX_W = 6,
  parameter int M_W   = 20,
  parameter int X_W   = 23
) (
  input  logic             clk,
  input  logic             we_tag,
  input  logic             we_xlat,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [M_W-1:0]   wr_tag,
  input  logic [X_W-1:0]   wr_xlat,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [M_W-1:0]   rd_tag,
  output logic [X_W-1:0]   rd_xlat
);
  localparam int DEPTH = 1 << IDX_W;

  logic [M_W-1:0] tag_mem  [DEPTH];
  logic [X_W-1:0] xlat_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_tag)  tag_mem[wr_idx]  <= wr_tag;
    if (we_xlat) xlat_mem[wr_idx] <= wr_xlat;
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_xlat = xlat_mem[rd_idx];
endmodule

// File: rtl/tlb_judge.sv
// Combinational decision: tag compare, valid check, rights check, frame join.
module tlb_judge
  import tlb_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 13
) (
  input  logic [VA_W-OFF_W:0]            tag_word,   // {tag, valid}
  input  logic [VA_W-OFF_W+RIGHTS_W-1:0] xlat_word,  // {frame, rights}
  input  logic [VA_W-1:0]                vaddr,
  input  logic                           is_fetch,
  input  logic                           is_store,
  input  logic                           sup,
  output xl_status_e                     status,
  output logic [2:0]                     perm,
  output logic [VA_W-1:0]                paddr
);
  localparam int TAG_W = VA_W - OFF_W;

  logic [TAG_W-1:0]    vpn, tag, frame;
  logic                vld;
  logic [RIGHTS_W-1:0] rights;
  logic                x_ok, r_ok, w_ok, granted;

  assign vpn    = vaddr[VA_W-1:OFF_W];
  assign tag    = tag_word[TAG_W:1];
  assign vld    = tag_word[0];
  assign frame  = xlat_word[TAG_W+RIGHTS_W-1:RIGHTS_W];
  assign rights = xlat_word[RIGHTS_W-1:0];

  // rights nibble: [0] user read/exec, [1] user write/super exec, [2] super read, [3] super write
  assign x_ok    = sup ? rights[1] : rights[0];
  assign r_ok    = sup ? rights[2] : rights[0];
  assign w_ok    = sup ? rights[3] : rights[1];
  assign granted = is_fetch ? x_ok : (is_store ? w_ok : r_ok);

  always_comb begin
    status = XS_HIT;
    perm   = 3'b000;
    paddr  = '0;
    if (tag != vpn) begin
      status = XS_NOMATCH;
    end else if (!vld) begin
      status = XS_INVALID;
    end else if (!granted) begin
      status = XS_RIGHTS;
    end else begin
      perm  = is_fetch ? 3'b001 : {r_ok, w_ok, 1'b0};
      paddr = {frame, vaddr[OFF_W-1:0]};
    end
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 13,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlat_en,
  input  logic             cfg_we,
  input  logic             cfg_itlb,
  input  logic             cfg_xr,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [VA_W-1:0]  cfg_wdata,
  input  logic             req_valid,
  input  logic [1:0]       req_kind,
  input  logic             req_super,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             rsp_valid,
  output logic [VA_W-1:0]  rsp_paddr,
  output logic [2:0]       rsp_perm,
  output logic [1:0]       rsp_status,
  output logic [2:0]       rsp_exc,
  output logic [VA_W-1:0]  fault_addr
);
  localparam int TAG_W = VA_W - OFF_W;
  localparam int M_W   = TAG_W + 1;
  localparam int X_W   = TAG_W + RIGHTS_W;

  // reserved write-data bits are dropped; the reduction keeps every bit referenced
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata;

  logic [M_W-1:0] wr_tag;
  logic [X_W-1:0] wr_xlat;
  assign wr_tag  = {cfg_wdata[VA_W-1:OFF_W], cfg_wdata[0]};
  assign wr_xlat = {cfg_wdata[VA_W-1:OFF_W], cfg_wdata[RIGHTS_LO+RIGHTS_W-1:RIGHTS_LO]};

  logic [IDX_W-1:0] lk_idx;
  assign lk_idx = req_vaddr[OFF_W+IDX_W-1:OFF_W];

  logic [M_W-1:0] side_tag  [SIDES];
  logic [X_W-1:0] side_xlat [SIDES];

  for (genvar g = 0; g < SIDES; g++) begin : g_side
    logic hit_side;
    assign hit_side = (cfg_itlb == (g == SIDE_INSN));
    tlb_table #(.IDX_W(IDX_W), .M_W(M_W), .X_W(X_W)) u_table (
      .clk     (clk),
      .we_tag  (cfg_we && hit_side && !cfg_xr),
      .we_xlat (cfg_we && hit_side &&  cfg_xr),
      .wr_idx  (cfg_idx),
      .wr_tag  (wr_tag),
      .wr_xlat (wr_xlat),
      .rd_idx  (lk_idx),
      .rd_tag  (side_tag[g]),
      .rd_xlat (side_xlat[g])
    );
  end

  logic is_fetch, is_store, side_sel;
  assign is_fetch = (req_kind == KIND_FETCH);
  assign is_store = (req_kind == KIND_STORE);
  assign side_sel = is_fetch ? 1'(SIDE_INSN) : 1'(SIDE_DATA);

  xl_status_e       j_status;
  logic [2:0]       j_perm;
  logic [VA_W-1:0]  j_paddr;

  tlb_judge #(.VA_W(VA_W), .OFF_W(OFF_W)) u_judge (
    .tag_word  (side_tag[side_sel]),
    .xlat_word (side_xlat[side_sel]),
    .vaddr     (req_vaddr),
    .is_fetch  (is_fetch),
    .is_store  (is_store),
    .sup       (req_super),
    .status    (j_status),
    .perm      (j_perm),
    .paddr     (j_paddr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_perm   <= '0;
      rsp_status <= XS_HIT;
      rsp_exc    <= XE_NONE;
      fault_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        if (!xlat_en) begin
          rsp_paddr  <= req_vaddr;
          rsp_perm   <= 3'b111;
          rsp_status <= XS_HIT;
          rsp_exc    <= XE_NONE;
        end else begin
          rsp_paddr  <= j_paddr;
          rsp_perm   <= j_perm;
          rsp_status <= j_status;
          rsp_exc    <= exc_of(j_status, is_fetch);
          if (j_status != XS_HIT) fault_addr <= req_vaddr;
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  assert_bypass_identity_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlat_en) |=> (rsp_paddr == $past(req_vaddr) && rsp_perm == 3'b111
                                 && rsp_status == XS_HIT));
  assert_offset_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == XS_HIT) |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));
  assert_fault_capture_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != XS_HIT) |-> fault_addr == $past(req_vaddr));
  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_status != XS_HIT) |-> $stable(fault_addr));
  assert_fault_zeroed_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status != XS_HIT) |-> (rsp_paddr == '0 && rsp_perm == 3'b000));
  assert_exc_iff_fail_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ((rsp_status == XS_HIT) == (rsp_exc == XE_NONE)));
  assert_miss_side_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_status == XS_NOMATCH || rsp_status == XS_INVALID))
      |-> rsp_exc == (($past(req_kind) == KIND_FETCH) ? XE_INSN_MISS : XE_DATA_MISS));
  assert_fetch_rights_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == XS_HIT && $past(req_kind) == KIND_FETCH && $past(xlat_en))
      |-> rsp_perm == 3'b001);
endmodule

// File: tb/test_tlb_xlate.sv
`timescale 1ns/1ps
module test_tlb_xlate;
  localparam int VA_W = 32, OFF_W = 13, IDX_W = 6;
  localparam logic [1:0] F = 2'd0, L = 2'd1, S = 2'd2;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic             xlat_en = 1'b1, cfg_we = 1'b0, cfg_itlb = 1'b0, cfg_xr = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [31:0]      cfg_wdata = '0;
  logic             req_valid = 1'b0, req_super = 1'b0;
  logic [1:0]       req_kind = '0;
  logic [31:0]      req_vaddr = '0;
  logic             rsp_valid;
  logic [31:0]      rsp_paddr, fault_addr;
  logic [2:0]       rsp_perm, rsp_exc;
  logic [1:0]       rsp_status;

  tlb_xlate #(.VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) i_tlb_xlate (
    .clk(clk), .rst(rst), .xlat_en(xlat_en), .cfg_we(cfg_we), .cfg_itlb(cfg_itlb),
    .cfg_xr(cfg_xr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .req_valid(req_valid),
    .req_kind(req_kind), .req_super(req_super), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_perm(rsp_perm),
    .rsp_status(rsp_status), .rsp_exc(rsp_exc), .fault_addr(fault_addr));

  typedef struct {
    logic [31:0] paddr; logic [2:0] perm; logic [1:0] st; logic [2:0] exc;
    logic [31:0] fa; int due; string rq;
  } item_t;

  item_t q[$];
  logic [31:0] mi[64], ti[64], md[64], td[64];   // reference copies of the tables
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] exp_fa = '0;
  logic en_b = 1'b1;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // reference result built from the requirement text
  function automatic item_t model(logic [1:0] k, logic sup, logic [31:0] va);
    item_t it;
    logic [31:0] m, t;
    logic r, w, x, ok;
    logic [5:0] ix;
    it.paddr = '0; it.perm = '0; it.st = 2'd0; it.exc = 3'd0; it.fa = '0; it.due = 0; it.rq = "";
    if (!en_b) begin
      it.paddr = va; it.perm = 3'b111; it.rq = "R10";
      return it;
    end
    ix = va[18:13];
    m = (k == F) ? mi[ix] : md[ix];
    t = (k == F) ? ti[ix] : td[ix];
    if (m[31:13] != va[31:13]) begin
      it.st = 2'd1; it.rq = "R3/R8";
    end else if (!m[0]) begin
      it.st = 2'd2; it.rq = "R4/R8";
    end else if (k == F) begin
      x = sup ? t[7] : t[6];
      if (x) begin it.perm = 3'b001; it.paddr = {t[31:13], va[12:0]}; it.rq = "R5/R7"; end
      else begin it.st = 2'd3; it.rq = "R5/R8/R11"; end
    end else begin
      r = sup ? t[8] : t[6];
      w = sup ? t[9] : t[7];
      ok = (k == S) ? w : r;
      if (ok) begin it.perm = {r, w, 1'b0}; it.paddr = {t[31:13], va[12:0]}; it.rq = "R6/R7"; end
      else begin it.st = 2'd3; it.rq = "R6/R8/R11"; end
    end
    if (it.st == 2'd1 || it.st == 2'd2) it.exc = (k == F) ? 3'd1 : 3'd2;
    if (it.st == 2'd3) it.exc = (k == F) ? 3'd3 : 3'd4;
    return it;
  endfunction

  task automatic push(item_t it, logic [31:0] va);
    if (it.st != 2'd0) exp_fa = va;
    it.fa = exp_fa;
    it.due = cyc + 1;
    q.push_back(it);
  endtask

  task automatic model_wr(logic it_side, logic xr, logic [5:0] ix, logic [31:0] d);
    if (it_side) begin if (xr) ti[ix] = d; else mi[ix] = d; end
    else         begin if (xr) td[ix] = d; else md[ix] = d; end
  endtask

  task automatic t_idle();
    @(negedge clk); req_valid = 0; cfg_we = 0;
  endtask

  task automatic t_cfg(logic it_side, logic xr, logic [5:0] ix, logic [31:0] d);
    @(negedge clk);
    req_valid = 0; cfg_we = 1; cfg_itlb = it_side; cfg_xr = xr; cfg_idx = ix; cfg_wdata = d;
    model_wr(it_side, xr, ix, d);
  endtask

  task automatic t_req(logic [1:0] k, logic sup, logic [31:0] va);
    @(negedge clk);
    cfg_we = 0; xlat_en = en_b;
    req_valid = 1; req_kind = k; req_super = sup; req_vaddr = va;
    push(model(k, sup, va), va);
  endtask

  // write and lookup in the same cycle: the lookup must see the old entry (R2)
  task automatic t_cfg_req(logic it_side, logic xr, logic [5:0] ix, logic [31:0] d,
                           logic [1:0] k, logic sup, logic [31:0] va);
    item_t it;
    @(negedge clk);
    xlat_en = en_b;
    cfg_we = 1; cfg_itlb = it_side; cfg_xr = xr; cfg_idx = ix; cfg_wdata = d;
    req_valid = 1; req_kind = k; req_super = sup; req_vaddr = va;
    it = model(k, sup, va);
    it.rq = {it.rq, "/R2"};
    push(it, va);
    model_wr(it_side, xr, ix, d);
  endtask

  // monitor: compares each response against the queue head due this cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (!rsp_valid) begin
          fails++;
          $display("FAIL R2: rsp_valid=0 expected=1");
        end else if (rsp_paddr !== e.paddr || rsp_perm !== e.perm || rsp_status !== e.st ||
                     rsp_exc !== e.exc || fault_addr !== e.fa) begin
          fails++;
          $display("FAIL %s: actual pa=%h perm=%b st=%0d exc=%0d fa=%h expected pa=%h perm=%b st=%0d exc=%0d fa=%h",
                   e.rq, rsp_paddr, rsp_perm, rsp_status, rsp_exc, fault_addr,
                   e.paddr, e.perm, e.st, e.exc, e.fa);
        end
      end else if (rsp_valid) begin
        checks++; fails++;
        $display("FAIL R2: rsp_valid=1 expected=0");
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  localparam logic [31:0] VA_I  = {19'h12345, 13'h0ABC};   // index 5
  localparam logic [31:0] VA_I2 = {19'h12385, 13'h0ABC};   // index 5, other tag
  localparam logic [31:0] VA_D  = {19'h00049, 13'h1F00};   // index 9

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst = 0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
    chk(fault_addr == 32'h0, "R1 fault_addr after reset", fault_addr, 32'h0);

    // fill both tables with random entries; tag low bits equal the index
    for (int i = 0; i < 64; i++) begin
      t_cfg(1'b1, 1'b0, 6'(i), {13'($urandom), 6'(i), 12'($urandom), 1'($urandom % 4 != 0)});
      t_cfg(1'b1, 1'b1, 6'(i), $urandom);
      t_cfg(1'b0, 1'b0, 6'(i), {13'($urandom), 6'(i), 12'($urandom), 1'($urandom % 4 != 0)});
      t_cfg(1'b0, 1'b1, 6'(i), $urandom);
    end
    t_idle();

    // R10: pass-through ignores table contents
    en_b = 0;
    t_req(F, 1'b0, 32'hDEAD_BEEF);
    t_req(S, 1'b1, 32'h1234_5678);
    t_req(L, 1'b0, VA_D);
    en_b = 1;
    t_idle();

    // R5/R7: instruction entry with supervisor execute only
    t_cfg(1'b1, 1'b0, 6'd5, {19'h12345, 12'h0, 1'b1});
    t_cfg(1'b1, 1'b1, 6'd5, {19'h70001, 13'h0080});
    t_req(F, 1'b1, VA_I);          // hit, perm 001
    t_req(F, 1'b0, VA_I);          // user fetch: rights fault, exc 3, R9 capture
    t_req(F, 1'b1, VA_I + 32'h10); // hit again; fault_addr holds (R9)
    t_req(F, 1'b1, VA_I2);         // R3: tag differs above index, exc 1
    t_idle();

    // R4 and R2 write timing
    t_cfg(1'b1, 1'b0, 6'd5, {19'h12345, 12'h0, 1'b0});
    t_req(F, 1'b1, VA_I);          // invalid, exc 1
    t_cfg_req(1'b1, 1'b0, 6'd5, {19'h12345, 12'h0, 1'b1}, F, 1'b1, VA_I);  // still invalid
    t_req(F, 1'b1, VA_I);          // now hit
    t_idle();

    // R6: data rights
    t_cfg(1'b0, 1'b0, 6'd9, {19'h00049, 12'h0, 1'b1});
    t_cfg(1'b0, 1'b1, 6'd9, {19'h0ABCD, 13'h0040});  // user read only
    t_req(L, 1'b0, VA_D);          // hit perm 100
    t_req(S, 1'b0, VA_D);          // store fault exc 4
    t_req(L, 1'b1, VA_D);          // supervisor has no read: fault
    t_cfg(1'b0, 1'b1, 6'd9, {19'h0ABCD, 13'h0300});  // supervisor read+write
    t_req(S, 1'b1, VA_D);          // hit perm 110
    t_req(L, 1'b0, VA_D);          // user read gone: fault
    t_cfg(1'b0, 1'b1, 6'd9, {19'h0ABCD, 13'h0080});  // user write only
    t_req(S, 1'b0, VA_D);          // hit perm 010
    t_req(L, 1'b0, VA_D);          // fault
    t_idle();

    // R5/R6 table separation
    t_cfg(1'b1, 1'b0, 6'd9, 32'h0);
    t_cfg(1'b0, 1'b0, 6'd5, 32'h0);
    t_req(F, 1'b1, VA_D);          // present only in data table: miss exc 1
    t_req(L, 1'b1, VA_I);          // present only in instruction table: miss exc 2
    t_idle();

    // random sweep over kinds, modes and mostly-present pages
    for (int n = 0; n < 600; n++) begin
      logic [1:0] k;
      logic [5:0] ix;
      logic [31:0] va, m;
      k  = 2'($urandom % 3);
      ix = 6'($urandom);
      m  = (k == F) ? mi[ix] : md[ix];
      va = ($urandom % 4 != 0) ? {m[31:13], 13'($urandom)} : $urandom;
      en_b = ($urandom % 16 != 0);
      t_req(k, 1'($urandom), va);
      if ($urandom % 8 == 0) t_idle();
    end
    en_b = 1;
    t_idle();
    t_idle();
    done = 1;
    chk(q.size() == 0, "R2 all responses seen", 32'(q.size()), 32'h0);
    summary();
    $finish;
  end
endmodule